// File: doc/BRIEF.md
# Dual-Rate Five-Tap Correlation Filter

This block smooths a stream of 10-bit unsigned detector samples ahead of a peak search. Samples arrive two per clock, as an even/odd pair, and the block returns two filtered values per clock. Each filtered value at centre position c is a weighted sum of the five samples from c−2 to c+2. The window is centred, so a result can only be formed once the sample two positions ahead of its centre has arrived.

The five signed weights sit in a register set. A controller can rewrite that set at any time through a parallel port with a single load strobe, and the stream does not stop. The arithmetic runs through three register stages: window capture, products, and sum. Results carry a valid flag and the sample index of the even result.

A frame is 256 samples, or 128 pairs. A frame-start flag on the first pair restarts the numbering. Positions whose window would reach outside the frame (the first two and the last two) are reported as zero. The last two positions are reported one cycle after the final pair of the frame.

Top module: `corr5_filter`

## Requirements
- R1: For each output, out_y0 = A·x[c−2] + B·x[c−1] + C·x[c] + D·x[c+1] + E·x[c+2], where c = out_index. out_y1 is the same sum with c+1. Samples are unsigned, weights are 8-bit two's complement (coef_a is A … coef_e is E), and results are 21-bit two's complement.
- R2: in_s0 carries sample 2k and in_s1 carries sample 2k+1 of pair k. A pair is taken on every clock with in_valid high. frame_start together with in_valid makes that pair pair 0. The pair count wraps to 0 after pair 127. out_index is always even.
- R3: A pair k ≥ 1 taken at clock edge N produces out_valid with out_index = 2k−2, visible after edge N+2.
- R4: Pair 0 produces no output. Pair 1 produces index 0 with both results zero. After pair 127 is taken at edge N, an output with index 254 and both results zero is visible after edge N+3.
- R5: Clocks without in_valid produce no output, except the single trailing output of R4.
- R6: A load strobe replaces all five weights together. A pair taken on the same edge as the strobe, or on a later edge, uses the new set. Pairs taken earlier keep the old set, even while still in the pipeline. Without a strobe the weights do not change.
- R7: While reset (synchronous, active low) is applied, out_valid is low. After reset the pair count is 0 and the weights are 1, 2, 4, 2, 1 for A to E.
- R8: frame_start in the middle of a frame restarts numbering. That pair gives no output, and the next pair gives index 0.
- R9: The extreme case (all samples 1023, all weights −128) gives exactly −654720, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample pair is present |
| frame_start | input | 1 | This pair is pair 0 of a frame |
| in_s0 | input | 10 | Even sample of the pair |
| in_s1 | input | 10 | Odd sample of the pair |
| coef_load | input | 1 | Load strobe for the weight set |
| coef_a | input | 8 | Weight A (sample c−2), signed |
| coef_b | input | 8 | Weight B (sample c−1), signed |
| coef_c | input | 8 | Weight C (centre), signed |
| coef_d | input | 8 | Weight D (sample c+1), signed |
| coef_e | input | 8 | Weight E (sample c+2), signed |
| out_valid | output | 1 | A result pair is present |
| out_index | output | 8 | Centre index of out_y0 |
| out_y0 | output | 21 | Result for centre out_index, signed |
| out_y1 | output | 21 | Result for centre out_index+1, signed |

## Verification
A wrong pair count or a stale history word shows up at the ports as a wrong out_index or wrong sums. Both appear two clocks after the pair that exposes the fault. A lost or extra trailing output shows up one clock after the last pair of a frame. A weight register that updates on the wrong edge corrupts exactly the results whose pairs straddle the strobe. For that reason the stimulus places strobes next to in-flight pairs and in idle cycles, and the scoreboard compares every result, with its arrival cycle, against values computed from the requirements.

// File: rtl/corr5_pkg.sv
// Shared structural constants of the dual-rate correlation filter.
// Assumes: window of five taps, two lanes (even and odd centre) per clock.
package corr5_pkg;
    localparam int TAPS  = 5;
    localparam int LANES = 2;
    localparam int HIST  = TAPS - 1;          // samples kept from earlier pairs
    localparam int WIN   = TAPS + LANES - 1;  // samples seen by both lanes
endpackage

// File: rtl/corr5_window.sv
// Window stage: tracks the pair number inside a frame, keeps the last four
// samples, holds the active weight set and registers stage 1 of the pipe.
// Assumes FRAME_LEN is a power of two and pairs are aligned to even samples.
module corr5_window
    import corr5_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int COEF_W    = 8,
    parameter int FRAME_LEN = 256,
    parameter int IDX_W     = $clog2(FRAME_LEN),
    parameter int INIT_A    = 1,
    parameter int INIT_B    = 2,
    parameter int INIT_C    = 4,
    parameter int INIT_D    = 2,
    parameter int INIT_E    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     frame_start,
    input  logic [SAMPLE_W-1:0]      in_s0,
    input  logic [SAMPLE_W-1:0]      in_s1,
    input  logic                     coef_load,
    input  logic signed [COEF_W-1:0] coef_new [TAPS],
    output logic                     s1_valid,
    output logic                     s1_edge,
    output logic [IDX_W-1:0]         s1_base,
    output logic [SAMPLE_W-1:0]      s1_win [WIN],
    output logic signed [COEF_W-1:0] s1_coef [TAPS]
);
    localparam int PAIRS  = FRAME_LEN / 2;
    localparam int PAIR_W = IDX_W - 1;
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);
    localparam logic [IDX_W-1:0]  TAIL_BASE = IDX_W'(FRAME_LEN - 2);
    localparam logic signed [COEF_W-1:0] INIT_SET [TAPS] = '{
        COEF_W'(INIT_A), COEF_W'(INIT_B), COEF_W'(INIT_C),
        COEF_W'(INIT_D), COEF_W'(INIT_E)};

    logic [PAIR_W-1:0]         cnt_q;
    logic [PAIR_W-1:0]         pair_k;
    logic                      tail_q;
    logic                      emit_pair;
    logic                      last_pair;
    logic [IDX_W-1:0]          pair_base;
    logic [SAMPLE_W-1:0]       hist_q [HIST];
    logic signed [COEF_W-1:0]  coef_q [TAPS];
    logic signed [COEF_W-1:0]  coef_eff [TAPS];

    // Decode the number of the incoming pair and what it emits.
    always_comb begin
        pair_k    = frame_start ? '0 : cnt_q;
        emit_pair = in_valid && (pair_k != '0);
        last_pair = in_valid && (pair_k == LAST_PAIR);
        pair_base = {pair_k - PAIR_W'(1), 1'b0};
    end

    // A strobe in this cycle already applies to the pair in this cycle.
    always_comb begin
        for (int t = 0; t < TAPS; t++)
            coef_eff[t] = coef_load ? coef_new[t] : coef_q[t];
    end

    // Pair counter: restarts on frame_start, wraps after the last pair.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (in_valid) cnt_q <= (pair_k == LAST_PAIR) ? '0 : pair_k + PAIR_W'(1);
    end

    // Flag the trailing edge output one cycle after the last pair.
    always_ff @(posedge clk) begin
        if (!rst_n) tail_q <= 1'b0;
        else        tail_q <= last_pair;
    end

    // Sample history: the two previous pairs, oldest first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int h = 0; h < HIST; h++) hist_q[h] <= '0;
        end else if (in_valid) begin
            hist_q[0] <= hist_q[2];
            hist_q[1] <= hist_q[3];
            hist_q[2] <= in_s0;
            hist_q[3] <= in_s1;
        end
    end

    // Active weight set, replaced as a whole on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TAPS; t++) coef_q[t] <= INIT_SET[t];
        end else if (coef_load) begin
            for (int t = 0; t < TAPS; t++) coef_q[t] <= coef_new[t];
        end
    end

    // Stage 1 control: valid, edge marker and base index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_edge  <= 1'b0;
            s1_base  <= '0;
        end else begin
            s1_valid <= emit_pair || tail_q;
            s1_edge  <= tail_q || (emit_pair && (pair_k == PAIR_W'(1)));
            s1_base  <= tail_q ? TAIL_BASE : pair_base;
        end
    end

    // Stage 1 data: six-sample window and a snapshot of the weights.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WIN; w++)  s1_win[w]  <= '0;
            for (int t = 0; t < TAPS; t++) s1_coef[t] <= INIT_SET[t];
        end else begin
            if (in_valid) begin
                for (int h = 0; h < HIST; h++) s1_win[h] <= hist_q[h];
                s1_win[HIST]     <= in_s0;
                s1_win[HIST + 1] <= in_s1;
            end
            for (int t = 0; t < TAPS; t++) s1_coef[t] <= coef_eff[t];
        end
    end

    // The last pair of a frame is followed by exactly one zero edge output.
    assert_tail_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last_pair |-> ##2 (s1_valid && s1_edge && s1_base == TAIL_BASE));

    // Idle input never creates stage 1 work except the trailing output.
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !tail_q) |=> !s1_valid);

    // Weights change only on the strobe.
    for (genvar t = 0; t < TAPS; t++) begin : g_coef_chk
        assert_coef_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !coef_load |=> $stable(coef_q[t]));
    end
endmodule

// File: rtl/corr5_lane.sv
// One arithmetic lane: stage 2 forms five signed products, stage 3 adds them.
// Assumes unsigned samples, signed weights, ACC_W >= SAMPLE_W+COEF_W+3.
module corr5_lane
    import corr5_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int COEF_W   = 8,
    parameter int ACC_W    = SAMPLE_W + COEF_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     edge_in,
    input  logic [SAMPLE_W-1:0]      samp [TAPS],
    input  logic signed [COEF_W-1:0] coef [TAPS],
    output logic signed [ACC_W-1:0]  sum_q
);
    localparam int P_W = SAMPLE_W + COEF_W + 1;

    logic signed [P_W-1:0]   s_ext [TAPS];
    logic signed [P_W-1:0]   c_ext [TAPS];
    logic signed [P_W-1:0]   prod_q [TAPS];
    logic signed [ACC_W-1:0] acc;
    logic                    all_nonneg;
    logic                    all_nonpos;

    // Widen operands: samples zero-extended, weights sign-extended.
    always_comb begin
        for (int t = 0; t < TAPS; t++) begin
            s_ext[t] = {{(P_W-SAMPLE_W){1'b0}}, samp[t]};
            c_ext[t] = {{(P_W-COEF_W){coef[t][COEF_W-1]}}, coef[t]};
        end
    end

    // Stage 2: products, forced to zero for frame-edge positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TAPS; t++) prod_q[t] <= '0;
        end else begin
            for (int t = 0; t < TAPS; t++)
                prod_q[t] <= edge_in ? '0 : s_ext[t] * c_ext[t];
        end
    end

    // Adder tree input: sign-extend each product to the accumulator width.
    always_comb begin
        acc        = '0;
        all_nonneg = 1'b1;
        all_nonpos = 1'b1;
        for (int t = 0; t < TAPS; t++) begin
            acc = acc + {{(ACC_W-P_W){prod_q[t][P_W-1]}}, prod_q[t]};
            if (prod_q[t][P_W-1])  all_nonneg = 1'b0;
            if (prod_q[t] > 0)     all_nonpos = 1'b0;
        end
    end

    // Stage 3: registered sum.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= acc;
    end

    // Edge positions reach the output as zero two stages later.
    assert_edge_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_in |-> ##2 (sum_q == '0));

    // The sum never wraps: its sign agrees with uniformly signed products.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        all_nonneg |=> !sum_q[ACC_W-1]);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        all_nonpos |=> (sum_q <= 0));
endmodule

// File: rtl/corr5_filter.sv
// Top: dual-rate five-tap centred correlation filter. Feeds the window stage
// into one arithmetic lane per centre and carries valid and index alongside.
// Assumes a frame of FRAME_LEN samples delivered as FRAME_LEN/2 pairs.
module corr5_filter
    import corr5_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int COEF_W    = 8,
    parameter int FRAME_LEN = 256,
    parameter int IDX_W     = $clog2(FRAME_LEN),
    parameter int ACC_W     = SAMPLE_W + COEF_W + 3,
    parameter int INIT_A    = 1,
    parameter int INIT_B    = 2,
    parameter int INIT_C    = 4,
    parameter int INIT_D    = 2,
    parameter int INIT_E    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     frame_start,
    input  logic [SAMPLE_W-1:0]      in_s0,
    input  logic [SAMPLE_W-1:0]      in_s1,
    input  logic                     coef_load,
    input  logic signed [COEF_W-1:0] coef_a,
    input  logic signed [COEF_W-1:0] coef_b,
    input  logic signed [COEF_W-1:0] coef_c,
    input  logic signed [COEF_W-1:0] coef_d,
    input  logic signed [COEF_W-1:0] coef_e,
    output logic                     out_valid,
    output logic [IDX_W-1:0]         out_index,
    output logic signed [ACC_W-1:0]  out_y0,
    output logic signed [ACC_W-1:0]  out_y1
);
    logic signed [COEF_W-1:0] coef_in [TAPS];
    logic                     s1_valid;
    logic                     s1_edge;
    logic [IDX_W-1:0]         s1_base;
    logic [SAMPLE_W-1:0]      s1_win [WIN];
    logic signed [COEF_W-1:0] s1_coef [TAPS];
    logic                     s2_valid;
    logic [IDX_W-1:0]         s2_idx;
    logic [SAMPLE_W-1:0]      lane_win [LANES][TAPS];
    logic signed [ACC_W-1:0]  lane_sum [LANES];

    assign coef_in[0] = coef_a;
    assign coef_in[1] = coef_b;
    assign coef_in[2] = coef_c;
    assign coef_in[3] = coef_d;
    assign coef_in[4] = coef_e;

    corr5_window #(
        .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W),
        .INIT_A(INIT_A), .INIT_B(INIT_B), .INIT_C(INIT_C),
        .INIT_D(INIT_D), .INIT_E(INIT_E)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
        .in_s0(in_s0), .in_s1(in_s1), .coef_load(coef_load), .coef_new(coef_in),
        .s1_valid(s1_valid), .s1_edge(s1_edge), .s1_base(s1_base),
        .s1_win(s1_win), .s1_coef(s1_coef)
    );

    // One lane per centre; lane L sees window samples L .. L+TAPS-1.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar t = 0; t < TAPS; t++) begin : g_tap
            assign lane_win[l][t] = s1_win[l + t];
        end
        corr5_lane #(
            .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .edge_in(s1_edge),
            .samp(lane_win[l]), .coef(s1_coef), .sum_q(lane_sum[l])
        );
    end

    // Valid and index travel beside the two arithmetic stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_idx    <= '0;
            out_valid <= 1'b0;
            out_index <= '0;
        end else begin
            s2_valid  <= s1_valid;
            s2_idx    <= s1_base;
            out_valid <= s2_valid;
            out_index <= s2_idx;
        end
    end

    assign out_y0 = lane_sum[0];
    assign out_y1 = lane_sum[1];

    // Stage 1 work emerges two clocks later with its index intact.
    assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> ##2 (out_valid && out_index == $past(s1_base, 2)));

    // Results always start on an even position.
    assert_even_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_index[0]);
endmodule

// File: tb/corr5_filter_test.sv
`timescale 1ns/1ps
module corr5_filter_test;
    localparam int FRAME = 256;
    localparam int PAIRS = FRAME / 2;
    localparam int TAG_R1 = 1, TAG_R4 = 4, TAG_R6 = 6, TAG_R8 = 8, TAG_R9 = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, frame_start = 1'b0, coef_load = 1'b0;
    logic [9:0] in_s0 = '0, in_s1 = '0;
    logic signed [7:0] coef_a = '0, coef_b = '0, coef_c = '0, coef_d = '0, coef_e = '0;
    logic out_valid;
    logic [7:0] out_index;
    logic signed [20:0] out_y0, out_y1;

    typedef struct {int idx; int y0; int y1; int at; int tag;} exp_t;
    exp_t q[$];

    int checks = 0, failures = 0, cyc = 0;
    int xs [FRAME];
    int cm [5] = '{1, 2, 4, 2, 1};
    int ld_c [5];
    bit ld_req = 1'b0;
    int bk = 0;
    int cur_tag = TAG_R1;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    corr5_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
        .in_s0(in_s0), .in_s1(in_s1), .coef_load(coef_load),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c), .coef_d(coef_d), .coef_e(coef_e),
        .out_valid(out_valid), .out_index(out_index), .out_y0(out_y0), .out_y1(out_y1)
    );

    function automatic string tname(int t);
        case (t)
            TAG_R1:  return "R1";
            TAG_R4:  return "R4";
            TAG_R6:  return "R6";
            TAG_R8:  return "R8";
            default: return "R9";
        endcase
    endfunction

    // Expected result for centre c, from the requirement formula.
    function automatic int fexp(int c);
        int s = 0;
        if (c < 2 || c > FRAME - 3) return 0;
        for (int t = 0; t < 5; t++) s += cm[t] * xs[c - 2 + t];
        return s;
    endfunction

    task automatic push(int idx, int y0, int y1, int at, int tag);
        exp_t e;
        e.idx = idx; e.y0 = y0; e.y1 = y1; e.at = at; e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: one clock of stimulus, expected results pushed to the queue.
    task automatic step(bit v, bit fs, int e, int o);
        int k;
        @(negedge clk);
        in_valid = v; frame_start = fs; in_s0 = e[9:0]; in_s1 = o[9:0];
        coef_load = ld_req;
        coef_a = ld_c[0][7:0]; coef_b = ld_c[1][7:0]; coef_c = ld_c[2][7:0];
        coef_d = ld_c[3][7:0]; coef_e = ld_c[4][7:0];
        if (ld_req) for (int t = 0; t < 5; t++) cm[t] = ld_c[t];
        ld_req = 1'b0;
        if (v) begin
            k = fs ? 0 : bk;
            xs[2*k] = e; xs[2*k + 1] = o;
            if (k != 0)
                push(2*k - 2, fexp(2*k - 2), fexp(2*k - 1), cyc + 3,
                     (k == 1) ? TAG_R4 : cur_tag);
            if (k == PAIRS - 1) push(FRAME - 2, 0, 0, cyc + 4, TAG_R4);
            bk = (k == PAIRS - 1) ? 0 : k + 1;
        end
    endtask

    task automatic load(int a, int b, int c, int d, int e);
        ld_c = '{a, b, c, d, e};
        ld_req = 1'b1;
    endtask

    task automatic drain();
        repeat (6) step(0, 0, 0, 0);
    endtask

    function automatic int gen(int i);
        return (i * 97 + 13) % 1024;
    endfunction

    // Monitor: pops the scoreboard whenever the design presents a result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R5 unexpected output idx=%0d expected none", out_index);
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cyc != e.at) begin
                    failures++;
                    $display("FAIL R3 idx=%0d cycle=%0d expected %0d", e.idx, cyc, e.at);
                end
                checks++;
                if (int'(out_index) != e.idx) begin
                    failures++;
                    $display("FAIL R2 index=%0d expected %0d", out_index, e.idx);
                end
                checks++;
                if (int'(out_y0) != e.y0 || int'(out_y1) != e.y1) begin
                    failures++;
                    $display("FAIL %s idx=%0d y0=%0d y1=%0d expected %0d %0d",
                             tname(e.tag), e.idx, out_y0, out_y1, e.y0, e.y1);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog expired, actual hung expected done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R7: outputs quiet under reset, defaults used afterwards.
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R7 out_valid=%b expected 0 in reset", out_valid);
        end
        rst_n = 1'b1;

        // R1, R7: full frame with reset weights, back-to-back pairs.
        cur_tag = TAG_R1;
        for (int p = 0; p < PAIRS; p++)
            step(1, p == 0, (6 * p) % 1024, (6 * p + 3) % 1024);
        drain();

        // R5: idle cycles with nothing queued produce nothing.
        for (int n = 0; n < 4; n++) begin
            step(0, 0, 0, 0);
            checks++;
            if (out_valid !== 1'b0) begin
                failures++;
                $display("FAIL R5 out_valid=%b expected 0 when idle", out_valid);
            end
        end

        // R6: gaps, a strobe together with a pair, a strobe in an idle cycle.
        cur_tag = TAG_R6;
        for (int p = 0; p < PAIRS; p++) begin
            if (p == 30) load(-3, 5, -128, 127, -1);
            step(1, p == 0, gen(2 * p), gen(2 * p + 1));
            if (p % 3 == 2) step(0, 0, 0, 0);
            if (p == 60) begin
                load(7, -7, 20, -20, 64);
                step(0, 0, 0, 0);
            end
        end
        drain();

        // R8: partial frame, then a restart; R9: extreme values.
        cur_tag = TAG_R8;
        for (int p = 0; p < 20; p++)
            step(1, p == 0, gen(2 * p + 5), gen(2 * p + 6));
        load(-128, -128, -128, -128, -128);
        for (int p = 0; p < PAIRS; p++) begin
            cur_tag = (p < 4) ? TAG_R8 : TAG_R9;
            step(1, p == 0, 1023, 1023);
        end
        drain();

        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R3 missing outputs=%0d expected 0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule